// File: doc/BRIEF.md
# Address Security Attribution Unit

This block assigns a security attribute to every 32-bit bus address seen by an embedded processor subsystem. The upper four address bits name one of sixteen regions. Even-numbered regions are non-secure and odd-numbered regions are secure. Two fixed windows near the top of the address map are marked exempt from attribution.

A small configuration register, written and read over a simple register port, can make selected secure regions callable from non-secure code. After reset no region is callable. The result can only tighten the attribution produced by the processor's own unit, never relax it.

A lookup is requested by pulsing a valid strobe together with an address. One cycle later the block presents registered results together with a single-cycle response-valid pulse. Between lookups the result fields keep their last values.

Top module: `addr_sec_attrib`

## Requirements
- R1: Every cycle with `lookup_valid` high is followed, one cycle later, by exactly one cycle with `resp_valid` high. `resp_valid` is never high otherwise. In that cycle `resp_region` equals bits 31..28 of the address presented with the strobe.
- R2: `resp_nonsec` is 1 when address bit 28 was 0 and 0 when it was 1, so an odd (secure) region is never reported non-secure.
- R3: `resp_callable` is 1 for region 1 exactly when configuration bit 0 is set, and for region 3 exactly when configuration bit 1 is set. It is 0 for every other region.
- R4: `resp_exempt` is 1 exactly when (address AND 0xEFF00000) equals 0xE0000000, that is, for 0xE0000000..0xE00FFFFF and 0xF0000000..0xF00FFFFF.
- R5: After reset the configuration register reads 0 and `resp_valid` is 0.
- R6: A configuration write stores `cfg_wr_data[1:0]` at the next rising edge. `cfg_rd_data` returns those two bits zero-extended to 32 bits. Write data bits 31..2 are ignored.
- R7: A configuration write issued in the same cycle as a lookup does not affect that lookup; it applies from the next lookup onward.
- R8: In a cycle after no lookup was requested, all four result fields keep their previous values.
- R9: `resp_callable` is never 1 together with `resp_nonsec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write data, bits 1..0 used |
| cfg_rd_data | output | 32 | Configuration read data, zero-extended |
| lookup_valid | input | 1 | Lookup request strobe |
| lookup_addr | input | 32 | Address to classify |
| resp_valid | output | 1 | Result valid pulse, one cycle after the request |
| resp_region | output | 4 | Region number |
| resp_nonsec | output | 1 | Region is non-secure |
| resp_callable | output | 1 | Secure region callable from non-secure code |
| resp_exempt | output | 1 | Address lies in an exempt window |

## Verification
The assertions assume that `lookup_valid` and `lookup_addr` are known values whenever the block is out of reset. They also assume that a configuration write is a one-cycle strobe. The bench drives every input at the falling edge and returns the strobes to 0 after a single cycle, so no assertion ever sees an undefined request. Lookups and writes are issued back to back, with idle gaps in between, so the same-cycle write ordering and the hold behaviour both arise under these assumptions.

// File: rtl/addr_sec_attrib.sv
module addr_sec_attrib #(
  parameter int ADDR_W = 32,
  parameter int REGION_W = 4,
  parameter int CFG_W = 2,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] EXEMPT_MASK = 32'hEFF0_0000,
  parameter logic [ADDR_W-1:0] EXEMPT_MATCH = 32'hE000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_en,
  input  logic [DATA_W-1:0]   cfg_wr_data,
  output logic [DATA_W-1:0]   cfg_rd_data,
  input  logic                lookup_valid,
  input  logic [ADDR_W-1:0]   lookup_addr,
  output logic                resp_valid,
  output logic [REGION_W-1:0] resp_region,
  output logic                resp_nonsec,
  output logic                resp_callable,
  output logic                resp_exempt
);
  localparam int REG_LSB = ADDR_W - REGION_W;

  logic [CFG_W-1:0]    cfg_q;
  logic [REGION_W-1:0] region;
  logic [CFG_W-1:0]    call_hit;
  logic                unused_wr_bits;

  assign unused_wr_bits = ^cfg_wr_data[DATA_W-1:CFG_W];
  assign region = lookup_addr[ADDR_W-1:REG_LSB];
  assign cfg_rd_data = {{(DATA_W-CFG_W){1'b0}}, cfg_q};

  // configuration bit i opens secure region 2*i+1
  for (genvar i = 0; i < CFG_W; i++) begin : g_call
    assign call_hit[i] = cfg_q[i] && (region == REGION_W'(2*i+1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr_en) cfg_q <= cfg_wr_data[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_region   <= '0;
      resp_nonsec   <= 1'b0;
      resp_callable <= 1'b0;
      resp_exempt   <= 1'b0;
    end else begin
      resp_valid <= lookup_valid;
      if (lookup_valid) begin
        resp_region   <= region;
        resp_nonsec   <= ~lookup_addr[REG_LSB];
        resp_callable <= |call_hit;
        resp_exempt   <= (lookup_addr & EXEMPT_MASK) == EXEMPT_MATCH;
      end
    end
  end

  // R1
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> resp_valid);
  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !resp_valid);
  // R1
  region_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> resp_region == $past(lookup_addr[ADDR_W-1:REG_LSB]));
  // R2
  secure_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_nonsec != resp_region[0]);
  // R4
  exempt_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_exempt) |-> resp_region[REGION_W-1:1] == '1);
  // R6
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data[CFG_W-1:0] == $past(cfg_wr_data[CFG_W-1:0]));
  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(cfg_rd_data));
  // R7
  same_cycle_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && cfg_wr_en && lookup_addr[ADDR_W-1:REG_LSB] == REGION_W'(1))
      |=> resp_callable == $past(cfg_rd_data[0]));
  // R8
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> $stable({resp_region, resp_nonsec, resp_callable, resp_exempt}));
  // R9
  callable_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_callable |-> !resp_nonsec);
endmodule

// File: tb/tb_addr_sec_attrib.sv
module tb_addr_sec_attrib;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        lookup_valid = 1'b0;
  logic [31:0] lookup_addr = '0;
  logic        resp_valid;
  logic [3:0]  resp_region;
  logic        resp_nonsec, resp_callable, resp_exempt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] model_cfg = 2'b00;
  logic [6:0] expq[$];
  logic [6:0] last_exp = '0;

  always #2 clk = ~clk;

  addr_sec_attrib dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .resp_valid(resp_valid), .resp_region(resp_region), .resp_nonsec(resp_nonsec),
    .resp_callable(resp_callable), .resp_exempt(resp_exempt));

  function automatic logic [6:0] ref_attr(input logic [31:0] a, input logic [1:0] c);
    logic [3:0] r;
    logic ns, nsc, ex;
    r = a[31:28];
    ns = (a[28] == 1'b0);
    nsc = (r == 4'd1 && c[0]) || (r == 4'd3 && c[1]);
    ex = (a[31:29] == 3'b111) && (a[27:20] == 8'h00);
    return {r, ns, nsc, ex};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one lookup, optionally with a configuration write in the same cycle
  task automatic lookup(input logic [31:0] a, input bit wr, input logic [31:0] wd);
    @(negedge clk);
    lookup_valid = 1'b1;
    lookup_addr = a;
    cfg_wr_en = wr;
    cfg_wr_data = wd;
    expq.push_back(ref_attr(a, model_cfg));
    if (wr) model_cfg = wd[1:0];
    @(negedge clk);
    lookup_valid = 1'b0;
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_write(input logic [31:0] wd);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = wd;
    model_cfg = wd[1:0];
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check(cfg_rd_data == {30'd0, wd[1:0]}, "R6", cfg_rd_data, {30'd0, wd[1:0]});
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R1", 32'd1, 32'd0);
      end else begin
        logic [6:0] e;
        e = expq.pop_front();
        last_exp = e;
        check(resp_region == e[6:3], "R1", 32'(resp_region), 32'(e[6:3]));
        check(resp_nonsec == e[2], "R2", 32'(resp_nonsec), 32'(e[2]));
        check(resp_callable == e[1], "R3 R7", 32'(resp_callable), 32'(e[1]));
        check(resp_exempt == e[0], "R4", 32'(resp_exempt), 32'(e[0]));
        check(!(resp_callable && resp_nonsec), "R9", 32'(resp_callable), 32'd0);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rd_data == 32'd0, "R5", cfg_rd_data, 32'd0);
    check(resp_valid == 1'b0, "R5", 32'(resp_valid), 32'd0);

    cfg_write(32'hFFFF_FFFF);
    cfg_write(32'hA5A5_A5A6);
    cfg_write(32'h0000_0000);

    for (int c = 0; c < 4; c++) begin
      cfg_write(32'hFFFF_FFF0 | 32'(c));
      for (int r = 0; r < 16; r++) lookup({r[3:0], 28'h0123456}, 1'b0, '0);
    end

    lookup(32'hE000_0000, 0, '0);
    lookup(32'hE00F_FFFF, 0, '0);
    lookup(32'hDFFF_FFFF, 0, '0);
    lookup(32'hE010_0000, 0, '0);
    lookup(32'hF000_0000, 0, '0);
    lookup(32'hF00F_FFFF, 0, '0);
    lookup(32'hEFFF_FFFF, 0, '0);
    lookup(32'hF010_0000, 0, '0);
    lookup(32'hE800_0000, 0, '0);

    // R7: same-cycle write does not affect its own lookup
    cfg_write(32'd0);
    lookup(32'h1000_0000, 1'b1, 32'd3);
    lookup(32'h1000_0000, 1'b0, '0);
    lookup(32'h3000_0000, 1'b1, 32'd0);
    lookup(32'h3000_0000, 1'b0, '0);

    // R8: fields hold while idle
    lookup(32'hF000_1234, 0, '0);
    repeat (3) @(negedge clk);
    check({resp_region, resp_nonsec, resp_callable, resp_exempt} == last_exp, "R8",
          32'({resp_region, resp_nonsec, resp_callable, resp_exempt}), 32'(last_exp));
    check(resp_valid == 1'b0, "R1", 32'(resp_valid), 32'd0);
    check(expq.size() == 0, "R1", 32'(expq.size()), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule